// File: doc/BRIEF.md
# Sequential Bus Breakpoint Comparator

This block sits beside a processor's bus and compares each bus cycle against four programmed breakpoint channels, named A, B, C and D. Every channel has a 32-bit target address with a 32-bit don't-care mask and an 8-bit cycle-condition byte. The byte selects the bus master, the access kind (instruction fetch or data), the direction and the operand size. Channels C and D also compare the bus data against a value under a don't-care mask. When a cycle qualifies, the block raises a one-cycle break request and latches a sticky per-channel hit flag.

A mode bit chains C and D. In chained mode a C hit only arms the pair, and the next D hit raises the break and disarms it. A and B keep working on their own in both modes. Instruction fetches are treated as read cycles at even addresses. A fetch that would need a write, or a fetch from an odd address, therefore never breaks, and a matching fetch breaks before the instruction executes. Software programs the channels and reads or clears the hit flags through a simple word-addressed register port.

Top module: `bus_break_unit`

## Requirements
- R1: A channel's address matches when, for every bit where its address mask holds 0, the bus address equals the programmed address. Mask bits at 1 are ignored in the comparison.
- R2: The cycle-condition byte is decoded as follows. Bits [1:0] give the master (bit0 allows CPU cycles, bit1 allows other masters). Bits [3:2] give the access kind (bit2 allows fetches, bit3 allows data accesses). Bits [5:4] give the direction (bit4 allows reads, bit5 allows writes). A cycle matches only if each field allows it.
- R3: Bits [7:6] of the condition byte set the size: 0 means any size, and 1, 2 and 3 require byte, word and longword respectively. The bus size input uses 0 for byte, 1 for word and 2 for longword.
- R4: Channels C and D also require the bus data to equal their data register on every bit where the data mask is 0. Channels A and B ignore the bus data.
- R5: A fetch counts as a read whatever the value of the write input, so a channel that allows writes only never matches a fetch.
- R6: A fetch cycle at an odd bus address never produces a hit on any channel.
- R7: With the chain bit set, a C hit raises no break and arms the pair. A D hit raises a break only while armed. A and B stay independent.
- R8: A D hit while armed disarms the pair, so a second D hit without a new C hit raises no break. A D hit while not armed sets no flag.
- R9: With the chain bit clear, a hit on any channel raises a break.
- R10: The break request is high for exactly the one clock after the edge that samples a qualifying cycle. It stays low after cycles that are idle or do not qualify.
- R11: Register map by word address: channel n at 4n+0 (address), 4n+1 (address mask) and 4n+2 (condition). Address 16 holds C data, 17 the C data mask, 18 D data, 19 the D data mask, and 20 the chain bit in bit 0. Address 21 holds the sticky hit flags in bits [3:0] (bit n for channel n, with C flagged on any C hit). Writing 1 to a flag bit clears it, and a new hit in the same cycle wins.
- R12: A channel whose condition byte is zero never hits.
- R13: After reset, all registers, flags and the break request are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| bus_cpu | input | 1 | 1 when the CPU is bus master |
| bus_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| brk_req | output | 1 | One-cycle break request |
| ch_hit | output | 4 | Sticky hit flags, bit n for channel n |

## Verification
The assertions assume at most one bus cycle per clock and a bus size that is never 3. They also assume that the hit flags change only through bus cycles or flag-register writes. The stimulus keeps to these limits. It draws bus sizes only from 0 to 2, presents one cycle per clock, and never overlaps a register write with a bus cycle. Random programming uses a small address and data range with sparse masks, so hits, chained sequences, odd fetches and write-only fetch conditions all occur often.

// File: rtl/bus_break_unit.sv
module bus_break_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_data,
  input  logic        bus_cpu,
  input  logic        bus_fetch,
  input  logic        bus_write,
  input  logic [1:0]  bus_size,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        brk_req,
  output logic [3:0]  ch_hit
);
  logic [31:0] ar [4];
  logic [31:0] am [4];
  logic [7:0]  cr [4];
  logic [31:0] dv [2];
  logic [31:0] dm [2];
  logic        seq, armed;
  logic [3:0]  hit, fire, flags, setf, clrf;

  wire eff_wr    = bus_write & ~bus_fetch;
  wire odd_fetch = bus_fetch & bus_addr[0];

  for (genvar i = 0; i < 4; i++) begin : g_ch
    logic cyc_ok, data_ok;
    assign cyc_ok = (bus_cpu   ? cr[i][0] : cr[i][1])
                  & (bus_fetch ? cr[i][2] : cr[i][3])
                  & (eff_wr    ? cr[i][5] : cr[i][4])
                  & ((cr[i][7:6] == 2'd0) | (cr[i][7:6] == bus_size + 2'd1));
    if (i >= 2) begin : g_dat
      assign data_ok = ((bus_data ^ dv[i-2]) & ~dm[i-2]) == 32'd0;
    end else begin : g_nodat
      assign data_ok = 1'b1;
    end
    assign hit[i] = bus_valid & ~odd_fetch & cyc_ok & data_ok
                  & (((bus_addr ^ ar[i]) & ~am[i]) == 32'd0);
  end

  assign fire   = {hit[3] & (~seq | armed), hit[2] & ~seq, hit[1:0]};
  assign setf   = {fire[3], hit[2:0]};
  assign clrf   = (reg_we && reg_addr == 5'd21) ? reg_wdata[3:0] : 4'd0;
  assign ch_hit = flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        ar[k] <= '0;
        am[k] <= '0;
        cr[k] <= '0;
      end
      for (int k = 0; k < 2; k++) begin
        dv[k] <= '0;
        dm[k] <= '0;
      end
      seq     <= 1'b0;
      armed   <= 1'b0;
      flags   <= '0;
      brk_req <= 1'b0;
    end else begin
      if (reg_we) begin
        if (!reg_addr[4]) begin
          case (reg_addr[1:0])
            2'd0: ar[reg_addr[3:2]] <= reg_wdata;
            2'd1: am[reg_addr[3:2]] <= reg_wdata;
            2'd2: cr[reg_addr[3:2]] <= reg_wdata[7:0];
            default: ;
          endcase
        end else begin
          case (reg_addr[3:0])
            4'd0: dv[0] <= reg_wdata;
            4'd1: dm[0] <= reg_wdata;
            4'd2: dv[1] <= reg_wdata;
            4'd3: dm[1] <= reg_wdata;
            4'd4: seq   <= reg_wdata[0];
            default: ;
          endcase
        end
      end
      brk_req <= |fire;
      armed   <= seq & (hit[2] | (armed & ~hit[3]));
      flags   <= (flags & ~clrf) | setf;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[4]) begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = ar[reg_addr[3:2]];
        2'd1: reg_rdata = am[reg_addr[3:2]];
        2'd2: reg_rdata = {24'd0, cr[reg_addr[3:2]]};
        default: ;
      endcase
    end else begin
      case (reg_addr[3:0])
        4'd0: reg_rdata = dv[0];
        4'd1: reg_rdata = dm[0];
        4'd2: reg_rdata = dv[1];
        4'd3: reg_rdata = dm[1];
        4'd4: reg_rdata = {31'd0, seq};
        4'd5: reg_rdata = {28'd0, flags};
        default: ;
      endcase
    end
  end
endmodule

module bus_break_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       bus_fetch,
  input logic       addr_lsb,
  input logic       brk_req,
  input logic [3:0] ch_hit
);
  // R11
  brk_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (ch_hit != 4'd0));
  // R11
  flag_needs_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_hit & ~$past(ch_hit)) != 4'd0) |-> $past(bus_valid));
  // R6
  odd_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_fetch && addr_lsb) |=> !brk_req);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !brk_req);
endmodule

bind bus_break_unit bus_break_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
  .addr_lsb(bus_addr[0]), .brk_req(brk_req), .ch_hit(ch_hit)
);

// File: tb/bus_break_unit_tb.sv
module bus_break_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_cpu = 0, bus_fetch = 0, bus_write = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic [1:0] bus_size = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic brk_req;
  logic [3:0] ch_hit;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_a [4], m_am [4], m_d [2], m_dm [2];
  logic [7:0] m_c [4];
  bit m_seq, m_arm;
  logic [3:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_break_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    if (!a[4]) begin
      case (a[1:0])
        2'd0: m_a[a[3:2]] = d;
        2'd1: m_am[a[3:2]] = d;
        2'd2: m_c[a[3:2]] = d[7:0];
        default: ;
      endcase
    end else begin
      case (a[3:0])
        4'd0: m_d[0] = d;
        4'd1: m_dm[0] = d;
        4'd2: m_d[1] = d;
        4'd3: m_dm[1] = d;
        4'd4: begin m_seq = d[0]; if (!d[0]) m_arm = 0; end
        4'd5: m_flags = m_flags & ~d[3:0];
        default: ;
      endcase
    end
    @(posedge clk); #1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  function automatic bit m_hit(input int ch, input logic [31:0] ad, input logic [31:0] da,
                               input bit cpu, input bit fe, input bit wr, input logic [1:0] sz);
    logic [7:0] c = m_c[ch];
    bit w = wr & ~fe;
    bit ok;
    if (fe && ad[0]) return 0;                                  // R6
    ok = (cpu ? c[0] : c[1]) && (fe ? c[2] : c[3]) && (w ? c[5] : c[4]);  // R2 R5
    ok = ok && (c[7:6] == 0 || c[7:6] == sz + 2'd1);            // R3
    ok = ok && (((ad ^ m_a[ch]) & ~m_am[ch]) == 0);             // R1
    if (ch >= 2) ok = ok && (((da ^ m_d[ch-2]) & ~m_dm[ch-2]) == 0);  // R4
    return ok;
  endfunction

  task automatic cyc(input string req, input logic [31:0] ad, input logic [31:0] da,
                     input bit cpu, input bit fe, input bit wr, input logic [1:0] sz);
    bit h [4];
    bit f3, brk;
    for (int k = 0; k < 4; k++) h[k] = m_hit(k, ad, da, cpu, fe, wr, sz);
    f3  = h[3] && (!m_seq || m_arm);
    brk = h[0] || h[1] || (h[2] && !m_seq) || f3;
    m_flags = m_flags | {f3, h[2], h[1], h[0]};
    m_arm = m_seq && (h[2] || (m_arm && !h[3]));
    bus_valid = 1; bus_addr = ad; bus_data = da; bus_cpu = cpu;
    bus_fetch = fe; bus_write = wr; bus_size = sz;
    @(posedge clk); #1;
    chk(req, {31'd0, brk_req}, {31'd0, brk});
    @(negedge clk);
    bus_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4; k++) begin m_a[k] = 0; m_am[k] = 0; m_c[k] = 0; end
    for (int k = 0; k < 2; k++) begin m_d[k] = 0; m_dm[k] = 0; end
    m_seq = 0; m_arm = 0; m_flags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    chk("R13 brk", {31'd0, brk_req}, 0);
    rd(5'd21, v); chk("R13 flags", v, 0);
    rd(5'd2, v);  chk("R13 cond", v, 0);
    rd(5'd16, v); chk("R13 data", v, 0);

    // R9 R1 channel A, CPU/any access/any dir/any size
    prog(5'd0, 32'h1000); prog(5'd2, 32'h3D);
    cyc("R9 A exact", 32'h1000, 0, 1, 0, 0, 2);
    cyc("R10 idle after", 32'h1000, 0, 1, 0, 0, 2);
    @(posedge clk); #1; chk("R10 pulse ends", {31'd0, brk_req}, 0); @(negedge clk);
    cyc("R1 addr miss", 32'h1004, 0, 1, 0, 0, 2);
    prog(5'd1, 32'hF);
    cyc("R1 masked hit", 32'h100C, 0, 1, 0, 1, 0);
    // R12 zero condition
    prog(5'd2, 0);
    cyc("R12 disabled", 32'h1000, 0, 1, 0, 0, 2);
    // R5 fetch + write-only
    prog(5'd1, 0); prog(5'd2, 32'h25);
    cyc("R5 fetch not write", 32'h1000, 0, 1, 1, 1, 1);
    // R6 odd fetch
    prog(5'd4, 32'h2001); prog(5'd6, 32'h35);
    cyc("R6 odd fetch", 32'h2001, 0, 1, 1, 0, 1);
    prog(5'd5, 32'h1);
    cyc("R6 even fetch masked", 32'h2000, 0, 1, 1, 0, 1);
    cyc("R6 odd fetch masked", 32'h2001, 0, 1, 1, 0, 1);
    // R3 size
    prog(5'd6, 32'hBD);
    cyc("R3 byte vs word", 32'h2000, 0, 1, 0, 0, 0);
    cyc("R3 word", 32'h2000, 0, 1, 0, 0, 1);
    // R2 master
    prog(5'd6, 32'h3E);
    cyc("R2 cpu rejected", 32'h2000, 0, 1, 0, 0, 1);
    cyc("R2 other master", 32'h2000, 0, 0, 0, 0, 1);
    // R4 data on C
    prog(5'd6, 0); prog(5'd8, 32'h3000); prog(5'd10, 32'h3D); prog(5'd16, 32'hDEAD);
    cyc("R4 data miss", 32'h3000, 32'hBEEF, 1, 0, 0, 2);
    cyc("R4 data hit", 32'h3000, 32'hDEAD, 1, 0, 0, 2);
    // R7 R8 chained
    prog(5'd16, 0); prog(5'd17, 32'hFFFF_FFFF);
    prog(5'd12, 32'h3008); prog(5'd14, 32'h3D); prog(5'd19, 32'hFFFF_FFFF);
    prog(5'd21, 32'hF); prog(5'd20, 1);
    cyc("R7 D unarmed", 32'h3008, 0, 1, 0, 0, 2);
    rd(5'd21, v); chk("R8 no D flag unarmed", v, 0);
    cyc("R7 C arms only", 32'h3000, 0, 1, 0, 0, 2);
    cyc("R7 D armed", 32'h3008, 0, 1, 0, 0, 2);
    cyc("R8 D disarmed", 32'h3008, 0, 1, 0, 0, 2);
    rd(5'd21, v); chk("R11 flags C D", v, 32'hC);
    prog(5'd21, 32'h4);
    rd(5'd21, v); chk("R11 w1c", v, 32'h8);
    rd(5'd20, v); chk("R11 chain bit", v, 1);

    // random phase
    for (int it = 0; it < 600; it++) begin
      if (it % 40 == 0) begin
        for (int k = 0; k < 4; k++) begin
          prog(5'(4*k),   $urandom % 64);
          prog(5'(4*k+1), $urandom % 4);
          prog(5'(4*k+2), ($urandom % 8 == 0) ? 0 : ($urandom % 256));
        end
        prog(5'd16, $urandom % 4); prog(5'd17, $urandom % 2);
        prog(5'd18, $urandom % 4); prog(5'd19, $urandom % 2);
        prog(5'd20, $urandom % 2);
      end
      cyc("R7 R9 random", $urandom % 64, $urandom % 4, 1'($urandom), 1'($urandom),
          1'($urandom), 2'($urandom % 3));
      if (it % 25 == 24) begin
        rd(5'd21, v); chk("R11 random flags", v, {28'd0, m_flags});
        prog(5'd21, $urandom % 16);
      end
    end
    rd(5'd21, v); chk("R11 final flags", v, {28'd0, m_flags});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule